// File: doc/BRIEF.md
# Snapshot Statistics Counter Bank

This block keeps a bank of frame-event statistics counters for a MAC. Each counter advances on a one-cycle event pulse. Frame counters add one per pulse. Byte counters add a per-event byte count of up to `MAX_BYTES`. Every counter is `CNT_W` bits wide and wraps modulo 2^`CNT_W`. Software reads a counter as three `SLICE_W`-bit words. A multi-word read would be torn if the live value moved between words, so software first writes a snapshot command. That command copies every live counter into its shadow register on the same clock edge, and all reads are served from the shadows.

A wrap of any counter sets that counter's rollover flag. The flags are packed `SLICE_W` per word into four words, and reading a word clears the flags it returned. Software can therefore count wraps and extend the hardware count beyond `CNT_W` bits. A clear command zeroes the whole bank at once. With the default parameters the bank holds twenty counters: receive octets, unicast, multicast, broadcast, pause, FCS errors, symbol errors, too-long, jabber, fragment, undersized, jumbo frames and jumbo octets, followed by transmit octets, unicast, multicast, broadcast, pause, jumbo frames and jumbo octets.

Top module: `evstat_bank`

## Requirements
- R1: After reset, every live counter, every shadow, every rollover flag and `host_rdata` are zero.
- R2: A frame counter (its `OCTET_MASK` bit clear) adds exactly one for each clock edge at which its `ev_pulse` bit is high. Pulses on other counters leave it unchanged.
- R3: A byte counter (its `OCTET_MASK` bit set) adds its field `ev_bytes[i*INC_W +: INC_W]`, a value from 0 to `MAX_BYTES`, at each edge where its pulse is high. The field has no effect while the pulse is low.
- R4: A write to address 0 with bit 0 of `host_wdata` set copies every live counter into its shadow at that edge. Each shadow takes the value the counter held before that edge's event. Shadows do not change between snapshots.
- R5: Counter i is read at word addresses 16+3i, 16+3i+1 and 16+3i+2. These return shadow bits [SLICE_W-1:0], bits [2*SLICE_W-1:SLICE_W] and bits [CNT_W-1:2*SLICE_W] zero-extended, in that order.
- R6: A write to address 0 with bit 1 set zeroes all live counters and, unless bit 0 is also set, all shadows. With both bits set, the shadows capture the values held before the clear.
- R7: When a clear command and an event pulse fall on the same edge, the counter ends at zero and no rollover flag is set.
- R8: A counter whose sum passes 2^`CNT_W`-1 keeps only the sum modulo 2^`CNT_W` and sets its rollover flag i on that edge.
- R9: Rollover word w (w = 0..3) is read at address 4+w and holds flags w*SLICE_W upward in its bits from bit 0. A read returns the flags and clears only that word. Flags in the other words keep their value.
- R10: `host_rdata` takes the addressed value one clock after an edge with `host_rd` high and holds it otherwise. The control address, unmapped addresses and flag bits beyond the last counter read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse | input | NUM_CNT | One event strobe per counter |
| ev_bytes | input | NUM_CNT*INC_W | Per-counter byte count, used by byte counters only |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | SLICE_W | Write data (control bits 0 and 1) |
| host_rdata | output | SLICE_W | Registered read data |

## Verification
The bank's state is visible only through the shadows and the flags. A live counter that drifted shows up after the next snapshot as a wrong value in one slice, and a stuck shadow shows up as a value that a second snapshot fails to update. A lost or stale rollover flag shows up on the first read of its word, or on the read after that when clear-on-read fails. The wrap test runs a reduced-width configuration to its exact boundary, so a carry that is one event early or late shows up directly in the flag word.

// File: rtl/evstat_pkg.sv
package evstat_pkg;

   // host register map (word addresses)
   localparam int CTRL_ADDR  = 0;
   localparam int ROLL_BASE  = 4;
   localparam int ROLL_WORDS = 4;
   localparam int CNT_BASE   = 16;

   // control word bits
   localparam int SNAP_BIT = 0;
   localparam int CLR_BIT  = 1;

   localparam int DEF_MAX_BYTES = 16;

   // default counter set
   localparam int IX_RX_OCT     = 0;
   localparam int IX_RX_UCAST   = 1;
   localparam int IX_RX_MCAST   = 2;
   localparam int IX_RX_BCAST   = 3;
   localparam int IX_RX_PAUSE   = 4;
   localparam int IX_RX_FCS     = 5;
   localparam int IX_RX_SYMBOL  = 6;
   localparam int IX_RX_LONG    = 7;
   localparam int IX_RX_JABBER  = 8;
   localparam int IX_RX_FRAG    = 9;
   localparam int IX_RX_UNDER   = 10;
   localparam int IX_RX_JUMBO   = 11;
   localparam int IX_RX_JOCT    = 12;
   localparam int IX_TX_OCT     = 13;
   localparam int IX_TX_UCAST   = 14;
   localparam int IX_TX_MCAST   = 15;
   localparam int IX_TX_BCAST   = 16;
   localparam int IX_TX_PAUSE   = 17;
   localparam int IX_TX_JUMBO   = 18;
   localparam int IX_TX_JOCT    = 19;
   localparam int DEF_NUM_CNT   = 20;

   localparam logic [63:0] DEF_OCTET_MASK =
      (64'd1 << IX_RX_OCT) | (64'd1 << IX_RX_JOCT) |
      (64'd1 << IX_TX_OCT) | (64'd1 << IX_TX_JOCT);

endpackage

// File: rtl/evstat_counter.sv
module evstat_counter #(
   parameter int CNT_W     = 40,
   parameter int INC_W     = 5,
   parameter int MAX_BYTES = 16,
   parameter bit IS_OCTET  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev,
   input  logic [INC_W-1:0] bytes,
   input  logic             snap,
   input  logic             clr,
   output logic [CNT_W-1:0] shadow,
   output logic             wrap
);

   logic [CNT_W-1:0] live;
   logic [INC_W-1:0] step;
   logic [CNT_W:0]   sum;

   generate
      if (IS_OCTET) begin : g_octet
         assign step = bytes;
      end else begin : g_frame
         logic unused_bytes;
         assign unused_bytes = ^bytes;
         assign step = INC_W'(1);
      end
   endgenerate

   assign sum  = {1'b0, live} + (CNT_W+1)'(step);
   assign wrap = ev & ~clr & sum[CNT_W];

   always_ff @(posedge clk) begin
      if (!rst_n)    live <= '0;
      else if (clr)  live <= '0;
      else if (ev)   live <= sum[CNT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     shadow <= '0;
      else if (snap)  shadow <= live;
      else if (clr)   shadow <= '0;
   end

   // R7
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (live == '0));

   // R4
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!snap && !clr) |=> $stable(shadow));

   // R3
   byte_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && IS_OCTET) |-> (bytes <= INC_W'(MAX_BYTES)));

   // R8
   wrap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (live < CNT_W'(MAX_BYTES)));

endmodule

// File: rtl/evstat_rollover.sv
module evstat_rollover #(
   parameter int NUM_CNT    = 20,
   parameter int SLICE_W    = 16,
   parameter int ROLL_WORDS = 4,
   localparam int FLAG_N    = ROLL_WORDS * SLICE_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_CNT-1:0]    wrap,
   input  logic [ROLL_WORDS-1:0] rd_clr,
   output logic [FLAG_N-1:0]     flags
);

   logic [FLAG_N-1:0] wrap_pad;
   assign wrap_pad = FLAG_N'(wrap);

   generate
      for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
         if (i < NUM_CNT) begin : g_used
            logic f_q;
            always_ff @(posedge clk) begin
               if (!rst_n) f_q <= 1'b0;
               else        f_q <= (f_q & ~rd_clr[i / SLICE_W]) | wrap[i];
            end
            assign flags[i] = f_q;
         end else begin : g_pad
            assign flags[i] = 1'b0;
         end
      end

      for (genvar w = 0; w < ROLL_WORDS; w++) begin : g_word_chk
         // R9
         read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr[w] && (wrap_pad[w*SLICE_W +: SLICE_W] == '0))
               |=> (flags[w*SLICE_W +: SLICE_W] == '0));
      end
   endgenerate

   // R8
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap != '0) |=> ((flags[NUM_CNT-1:0] & $past(wrap)) == $past(wrap)));

endmodule

// File: rtl/evstat_rdmux.sv
module evstat_rdmux
   import evstat_pkg::*;
#(
   parameter int NUM_CNT    = 20,
   parameter int CNT_W      = 40,
   parameter int SLICE_W    = 16,
   parameter int ADDR_W     = 8,
   localparam int FLAG_N    = ROLL_WORDS * SLICE_W
) (
   input  logic                            host_rd,
   input  logic [ADDR_W-1:0]               host_addr,
   input  logic [NUM_CNT-1:0][CNT_W-1:0]   shadow_all,
   input  logic [FLAG_N-1:0]               flags,
   output logic [SLICE_W-1:0]              rd_data,
   output logic [ROLL_WORDS-1:0]           roll_clr
);

   always_comb begin
      rd_data  = '0;
      roll_clr = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (host_addr == ADDR_W'(CNT_BASE + 3*i))
            rd_data = shadow_all[i][SLICE_W-1:0];
         if (host_addr == ADDR_W'(CNT_BASE + 3*i + 1))
            rd_data = shadow_all[i][2*SLICE_W-1:SLICE_W];
         if (host_addr == ADDR_W'(CNT_BASE + 3*i + 2))
            rd_data = SLICE_W'(shadow_all[i][CNT_W-1:2*SLICE_W]);
      end
      for (int w = 0; w < ROLL_WORDS; w++) begin
         if (host_addr == ADDR_W'(ROLL_BASE + w)) begin
            rd_data     = flags[w*SLICE_W +: SLICE_W];
            roll_clr[w] = host_rd;
         end
      end
   end

endmodule

// File: rtl/evstat_bank.sv
module evstat_bank
   import evstat_pkg::*;
#(
   parameter int NUM_CNT             = DEF_NUM_CNT,
   parameter int CNT_W               = 40,
   parameter int SLICE_W             = 16,
   parameter int MAX_BYTES           = DEF_MAX_BYTES,
   parameter int ADDR_W              = 8,
   parameter logic [NUM_CNT-1:0] OCTET_MASK = NUM_CNT'(DEF_OCTET_MASK),
   localparam int INC_W              = $clog2(MAX_BYTES + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CNT-1:0]         ev_pulse,
   input  logic [NUM_CNT*INC_W-1:0]   ev_bytes,
   input  logic                       host_wr,
   input  logic                       host_rd,
   input  logic [ADDR_W-1:0]          host_addr,
   input  logic [SLICE_W-1:0]         host_wdata,
   output logic [SLICE_W-1:0]         host_rdata
);

   localparam int FLAG_N = ROLL_WORDS * SLICE_W;

   initial begin : param_chk
      assert (CNT_W > 2*SLICE_W && CNT_W <= 3*SLICE_W);
      assert (NUM_CNT >= 1 && NUM_CNT <= FLAG_N);
      assert (CNT_BASE + 3*NUM_CNT <= (1 << ADDR_W));
      assert (ROLL_BASE + ROLL_WORDS <= CNT_BASE);
      assert (SLICE_W > CLR_BIT);
   end

   logic                          wr_ctrl, snap, clr;
   logic [NUM_CNT-1:0][CNT_W-1:0] shadow_all;
   logic [NUM_CNT-1:0]            wrap;
   logic [FLAG_N-1:0]             flags;
   logic [ROLL_WORDS-1:0]         roll_clr;
   logic [SLICE_W-1:0]            rd_data;
   logic                          unused_wdata;

   assign wr_ctrl = host_wr && (host_addr == ADDR_W'(CTRL_ADDR));
   assign snap    = wr_ctrl && host_wdata[SNAP_BIT];
   assign clr     = wr_ctrl && host_wdata[CLR_BIT];
   assign unused_wdata = ^host_wdata;

   generate
      for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
         evstat_counter #(
            .CNT_W     (CNT_W),
            .INC_W     (INC_W),
            .MAX_BYTES (MAX_BYTES),
            .IS_OCTET  (OCTET_MASK[i])
         ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .ev     (ev_pulse[i]),
            .bytes  (ev_bytes[i*INC_W +: INC_W]),
            .snap   (snap),
            .clr    (clr),
            .shadow (shadow_all[i]),
            .wrap   (wrap[i])
         );
      end
   endgenerate

   evstat_rollover #(
      .NUM_CNT    (NUM_CNT),
      .SLICE_W    (SLICE_W),
      .ROLL_WORDS (ROLL_WORDS)
   ) u_roll (
      .clk    (clk),
      .rst_n  (rst_n),
      .wrap   (wrap),
      .rd_clr (roll_clr),
      .flags  (flags)
   );

   evstat_rdmux #(
      .NUM_CNT (NUM_CNT),
      .CNT_W   (CNT_W),
      .SLICE_W (SLICE_W),
      .ADDR_W  (ADDR_W)
   ) u_rdmux (
      .host_rd    (host_rd),
      .host_addr  (host_addr),
      .shadow_all (shadow_all),
      .flags      (flags),
      .rd_data    (rd_data),
      .roll_clr   (roll_clr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       host_rdata <= '0;
      else if (host_rd) host_rdata <= rd_data;
   end

   // R10
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd |=> $stable(host_rdata));

   // R9
   clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(roll_clr));

endmodule

// File: tb/evstat_bank_test.sv
module evstat_bank_test;

   localparam int NC = 20;
   localparam int SW = 8;
   localparam int CW = 20;
   localparam int IW = 5;
   localparam int AW = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NC-1:0]   ev_pulse = '0;
   logic [NC*IW-1:0] ev_bytes = '0;
   logic            host_wr = 1'b0;
   logic            host_rd = 1'b0;
   logic [AW-1:0]   host_addr = '0;
   logic [SW-1:0]   host_wdata = '0;
   logic [SW-1:0]   host_rdata;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   evstat_bank #(
      .NUM_CNT    (NC),
      .CNT_W      (CW),
      .SLICE_W    (SW),
      .MAX_BYTES  (16),
      .ADDR_W     (AW),
      .OCTET_MASK (20'h83001)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_pulse   (ev_pulse),
      .ev_bytes   (ev_bytes),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [SW-1:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = AW'(a); host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [SW-1:0] v);
      @(negedge clk);
      host_rd = 1'b1; host_addr = AW'(a);
      @(negedge clk);
      host_rd = 1'b0;
      v = host_rdata;
   endtask

   task automatic rd_cnt(input int idx, output logic [3*SW-1:0] v);
      logic [SW-1:0] s0, s1, s2;
      rd(16 + 3*idx,     s0);
      rd(16 + 3*idx + 1, s1);
      rd(16 + 3*idx + 2, s2);
      v = {s2, s1, s0};
   endtask

   task automatic pump(input int idx, input int nbytes, input int n);
      @(negedge clk);
      ev_pulse[idx] = 1'b1;
      ev_bytes[idx*IW +: IW] = IW'(nbytes);
      repeat (n) @(negedge clk);
      ev_pulse[idx] = 1'b0;
      ev_bytes[idx*IW +: IW] = '0;
   endtask

   task automatic snap();
      wr(0, 8'h01);
   endtask

   task automatic t_reset();
      logic [3*SW-1:0] v;
      logic [SW-1:0] r;
      check(host_rdata == '0, "R1 rdata", longint'(host_rdata), 0);
      snap();
      rd_cnt(0, v);  check(v == 0, "R1 counter0", longint'(v), 0);
      rd_cnt(19, v); check(v == 0, "R1 counter19", longint'(v), 0);
      rd(4, r);      check(r == 0, "R1 roll word0", longint'(r), 0);
   endtask

   task automatic t_count();
      logic [3*SW-1:0] v;
      pump(1, 0, 7);
      pump(5, 0, 3);
      snap();
      rd_cnt(1, v); check(v == 7, "R2 counter1", longint'(v), 7);
      rd_cnt(5, v); check(v == 3, "R2 counter5", longint'(v), 3);
      rd_cnt(2, v); check(v == 0, "R2 untouched counter2", longint'(v), 0);
   endtask

   task automatic t_octet();
      logic [3*SW-1:0] v;
      pump(0, 16, 1);
      pump(0, 1, 1);
      pump(0, 0, 1);
      pump(0, 9, 1);
      // byte field without a pulse must not count (R3)
      @(negedge clk);
      ev_bytes[0 +: IW] = IW'(12);
      repeat (3) @(negedge clk);
      ev_bytes[0 +: IW] = '0;
      snap();
      rd_cnt(0, v); check(v == 26, "R3 octet sum", longint'(v), 26);
   endtask

   task automatic t_snap();
      logic [3*SW-1:0] v;
      pump(1, 0, 5);
      rd_cnt(1, v); check(v == 7, "R4 shadow held", longint'(v), 7);
      snap();
      rd_cnt(1, v); check(v == 12, "R4 resnap", longint'(v), 12);
      // snapshot and event on the same edge: shadow gets pre-event value
      @(negedge clk);
      host_wr = 1'b1; host_addr = '0; host_wdata = 8'h01; ev_pulse[3] = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; ev_pulse[3] = 1'b0;
      rd_cnt(3, v); check(v == 0, "R4 same-edge snapshot", longint'(v), 0);
      snap();
      rd_cnt(3, v); check(v == 1, "R4 event after snapshot", longint'(v), 1);
   endtask

   task automatic t_layout();
      logic [SW-1:0] r;
      pump(13, 16, 300);
      snap();
      rd(16 + 3*13,     r); check(r == 8'hC0, "R5 slice0", longint'(r), 'hC0);
      rd(16 + 3*13 + 1, r); check(r == 8'h12, "R5 slice1", longint'(r), 'h12);
      rd(16 + 3*13 + 2, r); check(r == 8'h00, "R5 slice2", longint'(r), 0);
   endtask

   task automatic t_clear();
      logic [3*SW-1:0] v;
      pump(2, 0, 4);
      wr(0, 8'h03);
      rd_cnt(2, v); check(v == 4, "R6 snap+clear keeps pre-clear", longint'(v), 4);
      snap();
      rd_cnt(2, v); check(v == 0, "R6 cleared counter2", longint'(v), 0);
      rd_cnt(1, v); check(v == 0, "R6 cleared counter1", longint'(v), 0);
      pump(2, 0, 2);
      snap();
      wr(0, 8'h02);
      rd_cnt(2, v); check(v == 0, "R6 clear zeroes shadow", longint'(v), 0);
      // clear and event on the same edge (R7)
      @(negedge clk);
      host_wr = 1'b1; host_addr = '0; host_wdata = 8'h02; ev_pulse[1] = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; ev_pulse[1] = 1'b0;
      snap();
      rd_cnt(1, v); check(v == 0, "R7 clear beats event", longint'(v), 0);
   endtask

   task automatic t_wrap();
      logic [3*SW-1:0] v;
      logic [SW-1:0] r;
      wr(0, 8'h02);
      @(negedge clk);
      ev_pulse[13] = 1'b1; ev_pulse[19] = 1'b1;
      ev_bytes[13*IW +: IW] = IW'(16); ev_bytes[19*IW +: IW] = IW'(16);
      repeat (65535) @(negedge clk);
      ev_bytes[13*IW +: IW] = IW'(15); ev_bytes[19*IW +: IW] = IW'(15);
      @(negedge clk);
      ev_pulse[13] = 1'b0; ev_pulse[19] = 1'b0;
      snap();
      rd_cnt(19, v); check(v == 24'h0FFFFF, "R5 full-scale slices", longint'(v), 'hFFFFF);
      rd(6, r); check(r == 0, "R8 no flag before wrap", longint'(r), 0);
      @(negedge clk);
      ev_pulse[13] = 1'b1; ev_pulse[19] = 1'b1;
      ev_bytes[13*IW +: IW] = IW'(3); ev_bytes[19*IW +: IW] = IW'(3);
      @(negedge clk);
      ev_pulse[13] = 1'b0; ev_pulse[19] = 1'b0;
      ev_bytes[13*IW +: IW] = '0; ev_bytes[19*IW +: IW] = '0;
      snap();
      rd_cnt(19, v); check(v == 2, "R8 modulo wrap value", longint'(v), 2);
      rd(6, r); check(r == 8'h08, "R8 flag counter19", longint'(r), 8);
      rd(6, r); check(r == 0, "R9 cleared on read", longint'(r), 0);
      rd(5, r); check(r == 8'h20, "R9 other word kept", longint'(r), 'h20);
      rd(5, r); check(r == 0, "R9 word1 cleared", longint'(r), 0);
      rd(4, r); check(r == 0, "R9 word0 empty", longint'(r), 0);
   endtask

   task automatic t_unmapped();
      logic [SW-1:0] r, held;
      rd(16 + 3*13, held);
      repeat (3) @(negedge clk);
      check(host_rdata == held, "R10 rdata holds", longint'(host_rdata), longint'(held));
      rd(0, r);           check(r == 0, "R10 control reads zero", longint'(r), 0);
      rd(9, r);           check(r == 0, "R10 gap address", longint'(r), 0);
      rd(16 + 3*NC, r);   check(r == 0, "R10 past last counter", longint'(r), 0);
      rd(8'hF0, r);       check(r == 0, "R10 high address", longint'(r), 0);
      rd(7, r);           check(r == 0, "R10 padding flags", longint'(r), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count();
      t_octet();
      t_snap();
      t_layout();
      t_clear();
      t_wrap();
      t_unmapped();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule